// File: doc/BRIEF.md
# Trimmed One-Second Divider with 64-Minute Correction Schedule

This block turns a 32,768 Hz oscillator, presented as a one-clock enable pulse on the system clock, into a single-cycle pulse once per second. Division runs in two stages. A first stage of 256 counts feeds a second stage of 128 chunks. The rate can be trimmed digitally. Once per minute, for a limited number of minutes, the block moves the end of one second. A positive trim removes half a first-stage chunk from that second. A negative trim inserts one whole extra chunk into it.

The trim comes from an 8-bit calibration byte with these fields:
- bits 4..0: magnitude N
- bit 5: direction
- bit 6: test-mode select
- bit 7: static output level

The block counts its own minutes in a repeating 64-minute cycle. The second at index 0 of each of the first 2×N minutes is corrected. The byte is captured only at minute boundaries. An output pin shows the static level bit. When the test-mode bit is set, the pin instead shows a square wave taken from the first divider stage.

There is no streaming data path. Every pin is plain control or status, with no handshake.

Top module: `rtc_trim_divider`

## Requirements
- R1: With no correction, a second lasts 2^LOW_W × CHUNKS enabled oscillator pulses (32,768 by default). `sec_tick` goes high for exactly one clock, in the cycle after the clock that sampled the final pulse of the second.
- R2: Only clock cycles with `osc_en` high advance the divider. Second lengths, counted in enabled pulses, do not depend on the gaps between pulses.
- R3: When bit 5 is 1 (positive trim), a corrected second is shortened by 2^(LOW_W-1) pulses (128 by default).
- R4: When bit 5 is 0 (negative trim), a corrected second is lengthened by 2^LOW_W pulses (256 by default).
- R5: Bits 4..0 hold magnitude N (0 to 31). Only second 0 of minute m is corrected, and only when m < 2×N. A full 64-minute cycle therefore contains exactly 2×N corrected seconds, and minutes 62 and 63 are never corrected.
- R6: A magnitude of 0 produces no correction, so every second has the nominal length.
- R7: `minute_idx` advances once every SECS_PER_MIN seconds, counts 0 to 63, wraps from 63 to 0, and changes in the same cycle that `sec_tick` rises.
- R8: The calibration byte is captured only at the boundary where a new minute starts. A change made inside a minute has no effect until the next minute. After reset the captured trim is zero.
- R9: When bit 6 is 0, `out_pin` equals bit 7. When bit 6 is 1, `out_pin` toggles at the rate of the first divider stage's most significant bit.
- R10: During and directly after reset, `sec_tick` is 0 and `minute_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-clock enable per oscillator period |
| cal_reg | input | 8 | Calibration byte: [7] level, [6] test select, [5] direction, [4:0] magnitude |
| sec_tick | output | 1 | One-clock pulse at the end of each second |
| minute_idx | output | 6 | Minute position inside the 64-minute cycle |
| out_pin | output | 1 | Static level or divider square wave |

## Verification
Two events can fall in the same clock:
- capture of the calibration byte at a minute boundary;
- the completion of the corrected second that begins that minute.

The same edge also decides whether the new second is trimmed. The bench provokes this in two ways. It raises the magnitude one second after a boundary, expecting the rest of that minute to stay nominal and the next minute's second 0 to be trimmed. It also aligns each full-cycle run on the 63-to-0 minute wrap, where the corrected second 0 of minute 0 follows directly.

Every second is judged by counting enabled pulses between ticks. The count is compared with a model that captures the trim only when it crosses a minute boundary.

// File: rtl/rtd_pkg.sv
package rtd_pkg;

  // Kind of adjustment applied to the second currently being counted
  typedef enum logic [1:0] {
    CORR_NONE  = 2'd0,
    CORR_SHORT = 2'd1,
    CORR_LONG  = 2'd2
  } corr_e;

  // Calibration byte layout; field positions are part of the register contract
  typedef struct packed {
    logic       out_level;
    logic       freq_test;
    logic       sign;
    logic [4:0] mag;
  } cal_t;

  localparam int unsigned CAL_MAG_W = 5;

endpackage

// File: rtl/rtd_div_chain.sv
module rtd_div_chain
  import rtd_pkg::*;
#(
  parameter int unsigned LOW_W  = 8,
  parameter int unsigned CHUNKS = 128
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  osc_en,
  input  corr_e corr,
  output logic  sec_done,
  output logic  sec_tick,
  output logic  sq_out
);

  localparam int unsigned CH_W = $clog2(CHUNKS + 1);
  localparam logic [LOW_W-1:0] LOW_LAST  = '1;
  localparam logic [LOW_W-1:0] HALF_LAST = {1'b0, {(LOW_W-1){1'b1}}};
  localparam logic [CH_W-1:0]  CH_NOM    = CH_W'(CHUNKS - 1);
  localparam logic [CH_W-1:0]  CH_EXT    = CH_W'(CHUNKS);

  logic [LOW_W-1:0] low_q;
  logic [CH_W-1:0]  chunk_q;
  logic [LOW_W-1:0] low_end;
  logic [CH_W-1:0]  chunk_end;
  logic             low_wrap;

  // First chunk of a shortened second is split in half; a lengthened
  // second gets one extra full chunk.
  always_comb begin
    low_end   = LOW_LAST;
    chunk_end = CH_NOM;
    if (corr == CORR_SHORT && chunk_q == '0) begin
      low_end = HALF_LAST;
    end
    if (corr == CORR_LONG) begin
      chunk_end = CH_EXT;
    end
  end

  assign low_wrap = osc_en && (low_q == low_end);
  assign sec_done = low_wrap && (chunk_q == chunk_end);
  assign sq_out   = low_q[LOW_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (osc_en) begin
      low_q <= low_wrap ? '0 : low_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chunk_q <= '0;
    end else if (low_wrap) begin
      chunk_q <= sec_done ? '0 : chunk_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= sec_done;
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> ($stable(low_q) && $stable(chunk_q))); // R2

endmodule

// File: rtl/rtd_cal_sched.sv
module rtd_cal_sched
  import rtd_pkg::*;
#(
  parameter int unsigned SECS_PER_MIN  = 60,
  parameter int unsigned MIN_PER_CYCLE = 64
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             sec_done,
  input  logic [CAL_MAG_W-1:0]             mag,
  input  logic                             sign,
  output corr_e                            corr,
  output logic [$clog2(MIN_PER_CYCLE)-1:0] minute_idx
);

  localparam int unsigned SEC_W = $clog2(SECS_PER_MIN);
  localparam int unsigned MIN_W = $clog2(MIN_PER_CYCLE);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECS_PER_MIN - 1);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_PER_CYCLE - 1);
  localparam int unsigned MAX_ELIG = 2 * ((1 << CAL_MAG_W) - 1);

  logic [SEC_W-1:0]     sec_q;
  logic [MIN_W-1:0]     minute_q;
  logic [CAL_MAG_W-1:0] mag_q;
  logic                 sign_q;
  logic                 min_end;

  assign min_end    = sec_done && (sec_q == SEC_LAST);
  assign minute_idx = minute_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
    end else if (sec_done) begin
      sec_q <= (sec_q == SEC_LAST) ? '0 : sec_q + 1'b1;
    end
  end

  // Minute counter and calibration capture share the minute boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      minute_q <= '0;
      mag_q    <= '0;
      sign_q   <= 1'b0;
    end else if (min_end) begin
      minute_q <= (minute_q == MIN_LAST) ? '0 : minute_q + 1'b1;
      mag_q    <= mag;
      sign_q   <= sign;
    end
  end

  always_comb begin
    corr = CORR_NONE;
    if (sec_q == '0 && (int'(minute_q) < 2 * int'(mag_q))) begin
      corr = sign_q ? CORR_SHORT : CORR_LONG;
    end
  end

  AST_MINUTE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (min_end && minute_q == MIN_LAST) |=> (minute_q == '0)); // R7

  AST_CAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !min_end |=> ($stable(mag_q) && $stable(sign_q))); // R8

  AST_LATE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(minute_q) >= int'(MAX_ELIG)) |-> (corr == CORR_NONE)); // R5

  AST_ZERO_MAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_q == '0) |-> (corr == CORR_NONE)); // R6

endmodule

// File: rtl/rtd_pin_mux.sv
module rtd_pin_mux (
  input  logic freq_test,
  input  logic out_level,
  input  logic sq_in,
  output logic out_pin
);

  always_comb begin
    if (freq_test) begin
      out_pin = sq_in;
    end else begin
      out_pin = out_level;
    end
  end

endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider
  import rtd_pkg::*;
#(
  parameter int unsigned LOW_W        = 8,
  parameter int unsigned CHUNKS       = 128,
  parameter int unsigned SECS_PER_MIN = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic [7:0] cal_reg,
  output logic       sec_tick,
  output logic [5:0] minute_idx,
  output logic       out_pin
);

  localparam int unsigned CYCLE_MIN = 64;

  cal_t  cal;
  corr_e corr;
  logic  sec_done;
  logic  sq;

  assign cal = cal_t'(cal_reg);

  rtd_div_chain #(
    .LOW_W  (LOW_W),
    .CHUNKS (CHUNKS)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .corr     (corr),
    .sec_done (sec_done),
    .sec_tick (sec_tick),
    .sq_out   (sq)
  );

  rtd_cal_sched #(
    .SECS_PER_MIN  (SECS_PER_MIN),
    .MIN_PER_CYCLE (CYCLE_MIN)
  ) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_done   (sec_done),
    .mag        (cal.mag),
    .sign       (cal.sign),
    .corr       (corr),
    .minute_idx (minute_idx)
  );

  rtd_pin_mux u_pin (
    .freq_test (cal.freq_test),
    .out_level (cal.out_level),
    .sq_in     (sq),
    .out_pin   (out_pin)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $rose(rst_n) |-> (!sec_tick && minute_idx == 6'd0)); // R10

endmodule

// File: tb/rtc_trim_divider_tb.sv
module rtc_trim_divider_tb;

  localparam int LOW_W  = 3;
  localparam int CHUNKS = 4;
  localparam int SPM    = 4;
  localparam int LOWN   = 1 << LOW_W;
  localparam int NOM    = LOWN * CHUNKS;
  localparam int SHORT  = NOM - LOWN / 2;
  localparam int LONG   = NOM + LOWN;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       sec_tick;
  logic [5:0] minute_idx;
  logic       out_pin;

  bit       b_lvl = 1'b0;
  bit       b_ft = 1'b0;
  bit       b_sign = 1'b0;
  bit [4:0] b_mag = 5'd0;
  logic [7:0] cal_reg;
  assign cal_reg = {b_lvl, b_ft, b_sign, b_mag};

  int n_checks = 0;
  int n_fail = 0;
  int pulse_cnt = 0;
  int last_len = 0;
  int tick_cnt = 0;
  int mdl_m = 0;
  int mdl_s = 0;
  int lat_mag = 0;
  bit lat_sign = 1'b0;
  int osc_gap = 0;
  int gap_ctr = 0;
  string cur_tag = "R1";
  bit done = 1'b0;
  event tick_ev;

  always #10 clk = ~clk;

  rtc_trim_divider #(
    .LOW_W        (LOW_W),
    .CHUNKS       (CHUNKS),
    .SECS_PER_MIN (SPM)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_en     (osc_en),
    .cal_reg    (cal_reg),
    .sec_tick   (sec_tick),
    .minute_idx (minute_idx),
    .out_pin    (out_pin)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(int m, int s, int mag, bit sign);
    if (s == 0 && m < 2 * mag) return sign ? SHORT : LONG;
    return NOM;
  endfunction

  // Reference model and oscillator pattern, evaluated away from the active edge
  always @(negedge clk) begin
    int e;
    if (!rst_n) begin
      pulse_cnt = 0;
      mdl_m = 0;
      mdl_s = 0;
      lat_mag = 0;
      lat_sign = 1'b0;
    end else begin
      if (osc_en) pulse_cnt++;
      if (sec_tick) begin
        e = exp_len(mdl_m, mdl_s, lat_mag, lat_sign);
        check(pulse_cnt == e, cur_tag, pulse_cnt, e);
        last_len = pulse_cnt;
        pulse_cnt = 0;
        tick_cnt++;
        mdl_s++;
        if (mdl_s == SPM) begin
          mdl_s = 0;
          mdl_m = (mdl_m + 1) % 64;
          lat_mag = b_mag;
          lat_sign = b_sign;
        end
        check(minute_idx == mdl_m, "R7", minute_idx, mdl_m);
        -> tick_ev;
      end
    end
    if (gap_ctr >= osc_gap) begin
      osc_en = 1'b1;
      gap_ctr = 0;
    end else begin
      osc_en = 1'b0;
      gap_ctr++;
    end
  end

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(sec_tick == 1'b0, "R10", sec_tick, 0);
    check(minute_idx == 6'd0, "R10", minute_idx, 0);
    check(out_pin == b_lvl, "R9", out_pin, b_lvl);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(sec_tick == 1'b0, "R10", sec_tick, 0);
    check(minute_idx == 6'd0, "R10", minute_idx, 0);
  endtask

  task automatic t_nominal();
    cur_tag = "R6";
    repeat (8) @(tick_ev);
    check(last_len == NOM, "R1", last_len, NOM);
  endtask

  // Full 64-minute cycle, aligned on the 63 -> 0 wrap
  task automatic t_cycle(input bit sign, input int mag, input int gap, input string tag);
    int seen;
    b_sign = sign;
    b_mag = 5'(mag);
    osc_gap = gap;
    cur_tag = tag;
    do @(tick_ev); while (mdl_m != 63);
    do @(tick_ev); while (!(mdl_m == 0 && mdl_s == 0));
    seen = 0;
    repeat (64 * SPM) begin
      @(tick_ev);
      if (last_len != NOM) seen++;
    end
    check(seen == 2 * mag, "R5", seen, 2 * mag);
  endtask

  // Magnitude change inside a minute waits for the next boundary
  task automatic t_midchange();
    int seen;
    cur_tag = "R8";
    osc_gap = 0;
    b_sign = 1'b1;
    b_mag = 5'd0;
    do @(tick_ev); while (!(mdl_m == 1 && mdl_s == 1));
    b_mag = 5'd31;
    seen = 0;
    repeat (SPM - 1) begin
      @(tick_ev);
      if (last_len != NOM) seen++;
    end
    check(seen == 0, "R8", seen, 0);
    @(tick_ev);
    check(last_len == SHORT, "R8", last_len, SHORT);
  endtask

  task automatic t_pin();
    int toggles;
    logic prev;
    b_ft = 1'b0;
    @(negedge clk);
    b_lvl = 1'b1;
    #1 check(out_pin == 1'b1, "R9", out_pin, 1);
    @(negedge clk);
    b_lvl = 1'b0;
    #1 check(out_pin == 1'b0, "R9", out_pin, 0);
    b_ft = 1'b1;
    @(negedge clk);
    prev = out_pin;
    toggles = 0;
    repeat (40) begin
      @(negedge clk);
      if (out_pin != prev) toggles++;
      prev = out_pin;
    end
    check(toggles >= 4, "R9", toggles, 4);
    b_ft = 1'b0;
    b_lvl = 1'b1;
    #1 check(out_pin == 1'b1, "R9", out_pin, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", tick_cnt, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_nominal();
    t_cycle(1'b1, 1, 0, "R3");
    t_cycle(1'b0, 31, 0, "R4");
    t_cycle(1'b1, 6, 1, "R2");
    t_midchange();
    t_pin();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule